// File: doc/BRIEF.md
# Write-Only Parallel Output Port

This block is a slave on a memory-mapped bus whose master issues byte addresses. It owns a single output register of `DATA_W` bits (16 by default) and drives that register straight onto a set of output pins. The block accepts writes only. It has no read path, no wait states, no bursts and no interrupt.

The incoming byte address is turned into a word index local to the slave. The index is the byte address shifted right by log2 of the data width in bytes. Only word index 0 selects the register. Each bit of the byte-enable vector gates one 8-bit lane of the write data, so software can update part of the pin bus without disturbing the rest.

A begin-transfer pulse may be wired to the block, because some fabrics provide one. The block does not depend on it.

Top module: `gpio_wr_slave`

## Requirements
- R1: While reset is high, the output pins go to all zeros at the next clock edge.
- R2: A write with word index 0 and all byte enables high loads the write data into the register. The pins show the new value after the clock edge at which the strobe is high.
- R3: Byte enable bit i controls pins [8i+7:8i]. A lane whose enable bit is 0 keeps its old value during a write, and a lane whose enable bit is 1 takes the matching write data bits.
- R4: A write with every byte enable low leaves the pins unchanged.
- R5: The word index is the byte address shifted right by log2(DATA_W/8), which is 1 for the default width. A write whose word index is not 0 (for example byte address 2 or 4) leaves the pins unchanged.
- R6: The address bits below the word boundary take no part in decoding, so a write to byte address 1 updates the register just as a write to byte address 0 does.
- R7: When the write strobe is low, the pins hold their value whatever the address, data and byte enables are.
- R8: The begin-transfer input has no effect on the pins, whether or not a write is in progress.
- R9: Writes complete with zero wait states. Writes held on consecutive cycles each update the pins at consecutive clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address from the master |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Byte-lane enables, bit i for bits [8i+7:8i] |
| bus_xfer_start | input | 1 | Begin-transfer pulse, accepted and not used |
| pins_out | output | DATA_W | Output register driven onto the pins |

## Verification
Writes are tried with full, single-lane and empty byte-enable patterns. These separate correct lane gating from a design that loads the whole word or swaps lanes. The address is stepped through byte offsets 0, 1, 2 and 4. This tells whether the index shift uses the right amount and whether sub-word bits leak into the decode. Idle cycles carrying live data and a toggling begin-transfer pulse, together with back-to-back writes, show whether the strobe alone governs the update and whether any cycle is lost between writes.

// File: rtl/gpio_wr_pkg.sv
package gpio_wr_pkg;
   function automatic int unsigned lane_count(input int unsigned width);
      return width / 8;
   endfunction

   function automatic int unsigned lane_shift(input int unsigned width);
      return (width / 8 > 1) ? $clog2(width / 8) : 0;
   endfunction
endpackage

// File: rtl/gpio_wr_decode.sv
module gpio_wr_decode #(
   parameter int ADDR_W = 8,
   parameter int SHIFT  = 1
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   logic idx_zero;

   generate
      if (SHIFT == 0) begin : g_no_shift
         assign idx_zero = (addr == '0);
      end else begin : g_shift
         logic [SHIFT-1:0] unused_offset;
         assign unused_offset = addr[SHIFT-1:0];
         assign idx_zero = (addr[ADDR_W-1:SHIFT] == '0);
      end
   endgenerate

   assign hit = wr & idx_zero;
endmodule

// File: rtl/gpio_wr_lanes.sv
module gpio_wr_lanes #(
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic              hit,
   input  logic [LANES-1:0]  be,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] cur,
   output logic [DATA_W-1:0] nxt
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign nxt[8*i +: 8] = (hit && be[i]) ? wdata[8*i +: 8] : cur[8*i +: 8];
   end
endmodule

// File: rtl/gpio_wr_slave.sv
module gpio_wr_slave
   import gpio_wr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 8
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic                   bus_wr,
   input  logic [DATA_W-1:0]      bus_wdata,
   input  logic [DATA_W/8-1:0]    bus_be,
   input  logic                   bus_xfer_start,
   output logic [DATA_W-1:0]      pins_out
);
   localparam int LANES = lane_count(DATA_W);
   localparam int SHIFT = lane_shift(DATA_W);

   if (DATA_W < 8 || DATA_W % 8 != 0)
      $error("DATA_W must be a positive multiple of 8");
   if ((LANES & (LANES - 1)) != 0)
      $error("DATA_W/8 must be a power of two");
   if (ADDR_W <= SHIFT)
      $error("ADDR_W must exceed the lane shift");

   logic              hit;
   logic [DATA_W-1:0] q, d;
   logic              unused_xfer_start;

   assign unused_xfer_start = bus_xfer_start;

   gpio_wr_decode #(.ADDR_W(ADDR_W), .SHIFT(SHIFT)) u_decode (
      .wr  (bus_wr),
      .addr(bus_addr),
      .hit (hit)
   );

   gpio_wr_lanes #(.DATA_W(DATA_W), .LANES(LANES)) u_lanes (
      .hit  (hit),
      .be   (bus_be),
      .wdata(bus_wdata),
      .cur  (q),
      .nxt  (d)
   );

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end

   assign pins_out = q;
endmodule

// File: rtl/gpio_wr_slave_chk.sv
module gpio_wr_slave_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 8
) (
   input logic                clk,
   input logic                rst,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W/8-1:0] bus_be,
   input logic [DATA_W-1:0]   pins_out
);
   localparam int LANES = DATA_W / 8;
   localparam int SHIFT = (LANES > 1) ? $clog2(LANES) : 0;

   logic idx0;
   assign idx0 = ((bus_addr >> SHIFT) == '0);

   a_r1_reset_zero: assert property (@(posedge clk) rst |=> pins_out == '0);

   a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !bus_wr |=> $stable(pins_out));

   a_r5_other_index: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && !idx0) |=> $stable(pins_out));

   a_r4_no_lanes: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_be == '0) |=> $stable(pins_out));

   a_r2_full_load: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && idx0 && (&bus_be)) |=> pins_out == $past(bus_wdata));

   for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
      a_r3_lane_off: assert property (@(posedge clk) disable iff (rst)
         (bus_wr && idx0 && !bus_be[i]) |=> $stable(pins_out[8*i +: 8]));
      a_r3_lane_on: assert property (@(posedge clk) disable iff (rst)
         (bus_wr && idx0 && bus_be[i]) |=> pins_out[8*i +: 8] == $past(bus_wdata[8*i +: 8]));
   end
endmodule

bind gpio_wr_slave gpio_wr_slave_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_wdata(bus_wdata),
   .bus_be   (bus_be),
   .pins_out (pins_out)
);

// File: tb/test_gpio_wr_slave.sv
`timescale 1ns/1ps
module test_gpio_wr_slave;
   localparam int DW = 16;
   localparam int AW = 8;

   typedef struct {
      logic [DW-1:0] exp;
      int            due;
      string         tag;
   } item_t;

   logic          clk = 0;
   logic          rst = 1;
   logic [AW-1:0] addr = '0;
   logic          wr = 0;
   logic [DW-1:0] wdata = '0;
   logic [1:0]    be = '0;
   logic          xs = 0;
   logic [DW-1:0] pins;

   int            cyc = 0;
   int            n_run = 0;
   int            n_fail = 0;
   logic [DW-1:0] model = '0;
   item_t         q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   gpio_wr_slave #(.DATA_W(DW), .ADDR_W(AW)) i_gpio_wr_slave (
      .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
      .bus_be(be), .bus_xfer_start(xs), .pins_out(pins)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // driver: one bus cycle, expected value pushed for the following edge
   task automatic drive(input string tag, input logic w, input logic [AW-1:0] a,
                        input logic [1:0] b, input logic [DW-1:0] d, input logic s);
      item_t it;
      @(negedge clk);
      wr = w; addr = a; be = b; wdata = d; xs = s;
      if (w && (a >> 1) == 0) begin
         if (b[0]) model[7:0]  = d[7:0];
         if (b[1]) model[15:8] = d[15:8];
      end
      it.exp = model; it.due = cyc + 1; it.tag = tag;
      q.push_back(it);
   endtask

   // monitor: compare once the due edge has passed
   always @(negedge clk) begin
      if (q.size() > 0 && q[0].due <= cyc) begin
         item_t it;
         it = q.pop_front();
         check(it.tag, pins, it.exp);
      end
   end

   task automatic drain();
      drive("R7 idle", 0, 8'h00, 2'b00, 16'h0000, 0);
      while (q.size() > 0) @(negedge clk);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", pins, 16'h0000);
      rst = 0;
      drive("R2 full write",        1, 8'h00, 2'b11, 16'hA5C3, 0);
      drive("R3 low lane",          1, 8'h00, 2'b01, 16'h1234, 0);
      drive("R3 high lane",         1, 8'h00, 2'b10, 16'h5678, 0);
      drive("R4 no lanes",          1, 8'h00, 2'b00, 16'hFFFF, 0);
      drive("R5 byte addr 2",       1, 8'h02, 2'b11, 16'h0000, 0);
      drive("R5 byte addr 4",       1, 8'h04, 2'b11, 16'h0000, 0);
      drive("R5 byte addr 0x80",    1, 8'h80, 2'b11, 16'h0000, 0);
      drive("R6 byte addr 1",       1, 8'h01, 2'b11, 16'h0F0F, 0);
      drive("R7 strobe low",        0, 8'h00, 2'b11, 16'h1111, 0);
      drive("R8 start without write", 0, 8'h00, 2'b11, 16'h2222, 1);
      drive("R8 start with write",  1, 8'h00, 2'b11, 16'h3C3C, 1);
      drive("R8 write after start", 1, 8'h00, 2'b01, 16'h00E1, 0);
      drive("R9 back-to-back 1",    1, 8'h00, 2'b11, 16'h1001, 0);
      drive("R9 back-to-back 2",    1, 8'h01, 2'b11, 16'h2002, 0);
      drive("R9 back-to-back 3",    1, 8'h00, 2'b10, 16'h3F03, 0);
      drain();
      @(negedge clk);
      rst = 1;
      @(negedge clk);
      rst = 0;
      model = '0;
      check("R1 reset mid-run", pins, 16'h0000);
      drive("R2 write after reset", 1, 8'h00, 2'b11, 16'hBEEF, 0);
      drain();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule